// File: doc/BRIEF.md
# Latency-Configurable Three-Port Memory

This block is a synchronous word memory with three access points on one clock: a read-only port, a write-only port and a shared port that either reads or writes in a given cycle. The storage core reads combinationally and writes on the clock edge. All extra latency is built from register stages around that core. Parameters set the read latency, the write latency and the policy for a read that meets a write to the same word in the same cycle.

The collision policy decides where the read latency registers sit. Under the write-first or undefined policy, the read enable and read address are registered ahead of the core. A read that lands on the same edge as a write then returns the freshly written word. Under the read-first policy, the core is read at once and the data word is carried through the latency registers. The word returned is the one stored before the colliding write. Every write path, the shared port's included, delays its enable, mask, address and data by one stage fewer than the write latency. The core itself contributes the last edge.

The policy parameter `RUW` takes `RUW_NEW` (0, write-first), `RUW_OLD` (1, read-first) or `RUW_UNDEF` (2, built like write-first). Both `RD_LAT` and `WR_LAT` must be at least 1. Edge n is the rising edge that ends cycle n, the cycle in which a command is presented.

Top module: `lat_mem_wrap`

## Requirements
- R1: A write-port command with wr_en=1 and wr_mask=1 in cycle n stores wr_data at wr_addr on edge n+WR_LAT-1.
- R2: A write-port command with wr_mask=0 stores nothing, and the addressed word keeps its previous value.
- R3: With RUW_NEW or RUW_UNDEF, rd_en=1 in cycle n makes rd_data show, between edge n+RD_LAT-1 and the following edge, the word stored at rd_addr after edge n+RD_LAT-1.
- R4: With RUW_OLD, rd_en=1 in cycle n makes rd_data show, between edge n+RD_LAT-1 and the following edge, the word stored at rd_addr before edge n. The word passes through RD_LAT data registers.
- R5: When a read and a write to the same word reach the core on the same edge, write-first returns the new word and read-first returns the old word.
- R6: On the shared port, rw_en=1 with rw_wmode=1 and rw_wmask=1 in cycle n stores rw_wdata at rw_addr on edge n+WR_LAT-1. rw_wmask=0 stores nothing.
- R7: On the shared port, rw_en=1 with rw_wmode=0 is a read. It returns on rw_rdata with the same latency and policy as R3 or R4.
- R8: When the write port and the shared port store to the same word on the same edge, the write port's data is kept.
- R9: While rst is high, no word is stored. Write commands still in the delay stages when rst is applied are dropped. Stored words survive the reset.
- R10: With RUW_NEW and rd_en=0, the registered read address holds, so rd_data keeps following the word at the last enabled address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous active-high reset; blocks stores and clears write enables in flight |
| rd_en | input | 1 | Read-port enable |
| rd_addr | input | $clog2(DEPTH) | Read-port word address |
| rd_data | output | DATA_W | Read-port data |
| wr_en | input | 1 | Write-port enable |
| wr_mask | input | 1 | Write-port word mask, 1 stores |
| wr_addr | input | $clog2(DEPTH) | Write-port word address |
| wr_data | input | DATA_W | Write-port data |
| rw_en | input | 1 | Shared-port enable |
| rw_wmode | input | 1 | Shared-port direction, 1 write, 0 read |
| rw_wmask | input | 1 | Shared-port word mask for writes |
| rw_addr | input | $clog2(DEPTH) | Shared-port word address |
| rw_wdata | input | DATA_W | Shared-port write data |
| rw_rdata | output | DATA_W | Shared-port read data |

## Verification
A write stage that is misaligned or badly cleared corrupts a stored word silently. The damage only shows up at the next read of that word. The bench therefore mixes reads in with the writes and steers half the addresses onto four words, so that a bad store is read back within a few cycles. A misplaced read-address register or a wrong policy shows up at once. A colliding read then returns the wrong one of the old and new words, in the very cycle it is due. A wrong latency makes a whole stream of reads one cycle early or late. A write-first and a read-first instance, with different latencies, run the same traffic side by side.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  // read-during-write policy of the wrapper
  typedef enum logic [1:0] {
    RUW_NEW   = 2'd0,
    RUW_OLD   = 2'd1,
    RUW_UNDEF = 2'd2
  } ruw_e;
endpackage

// File: rtl/lmw_pipe.sv
// Plain delay line of N register stages (N >= 1); optional clear on rst.
module lmw_pipe #(
  parameter int W   = 1,
  parameter int N   = 1,
  parameter bit CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [N-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (CLR && rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < N; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/lmw_rd_front.sv
// Read control delay for the write-first policy: the enable runs LAT-1
// stages, the address LAT stages, and each address stage loads only
// when the enable beside it is high.
module lmw_rd_front #(
  parameter int AW  = 5,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_q
);
  if (LAT == 1) begin : g_one
    logic [AW-1:0] a_r;
    always_ff @(posedge clk) begin
      if (en) a_r <= addr;
    end
    assign addr_q = a_r;
  end else begin : g_multi
    logic [LAT-2:0]         en_r;
    logic [LAT-1:0][AW-1:0] a_r;
    always_ff @(posedge clk) begin
      en_r[0] <= en;
      for (int i = 1; i < LAT - 1; i++) en_r[i] <= en_r[i-1];
      if (en) a_r[0] <= addr;
      for (int i = 1; i < LAT; i++) begin
        if (en_r[i-1]) a_r[i] <= a_r[i-1];
      end
    end
    assign addr_q = a_r[LAT-1];
  end
endmodule

// File: rtl/lmw_array.sv
// Storage core: two asynchronous reads, two edge-triggered writes.
// Port A is applied last, so it wins on an address clash.
module lmw_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wa_we,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (wb_we) mem[wb_addr] <= wb_data;
      if (wa_we) mem[wa_addr] <= wa_data;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/lat_mem_wrap.sv
module lat_mem_wrap
  import lmw_pkg::*;
#(
  parameter int   DATA_W = 32,
  parameter int   DEPTH  = 32,
  parameter int   RD_LAT = 1,
  parameter int   WR_LAT = 1,
  parameter ruw_e RUW    = RUW_NEW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic                     wr_mask,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rw_en,
  input  logic                     rw_wmode,
  input  logic                     rw_wmask,
  input  logic [$clog2(DEPTH)-1:0] rw_addr,
  input  logic [DATA_W-1:0]        rw_wdata,
  output logic [DATA_W-1:0]        rw_rdata
);
  localparam int AW        = $clog2(DEPTH);
  localparam int WSTG      = WR_LAT - 1;
  localparam int PAY_W     = 1 + AW + DATA_W;
  localparam bit DATA_SIDE = (RUW == RUW_OLD);

  // ---------------- write port ----------------
  logic              wq_en, wq_mask;
  logic [AW-1:0]     wq_addr;
  logic [DATA_W-1:0] wq_data;

  if (WR_LAT > 1) begin : g_wr_dly
    lmw_pipe #(.W(1), .N(WSTG), .CLR(1'b1)) u_en (
      .clk(clk), .rst(rst), .d(wr_en), .q(wq_en));
    lmw_pipe #(.W(PAY_W), .N(WSTG), .CLR(1'b0)) u_pay (
      .clk(clk), .rst(rst),
      .d({wr_mask, wr_addr, wr_data}),
      .q({wq_mask, wq_addr, wq_data}));
  end else begin : g_wr_thru
    assign wq_en   = wr_en;
    assign wq_mask = wr_mask;
    assign wq_addr = wr_addr;
    assign wq_data = wr_data;
  end

  // ---------------- shared port, write half ----------------
  logic              bq_en, bq_mask;
  logic [AW-1:0]     bq_addr;
  logic [DATA_W-1:0] bq_data;
  logic              rw_we_raw, rw_re_raw;

  assign rw_we_raw = rw_en & rw_wmode;
  assign rw_re_raw = rw_en & ~rw_wmode;

  if (WR_LAT > 1) begin : g_rw_dly
    lmw_pipe #(.W(1), .N(WSTG), .CLR(1'b1)) u_en (
      .clk(clk), .rst(rst), .d(rw_we_raw), .q(bq_en));
    lmw_pipe #(.W(PAY_W), .N(WSTG), .CLR(1'b0)) u_pay (
      .clk(clk), .rst(rst),
      .d({rw_wmask, rw_addr, rw_wdata}),
      .q({bq_mask, bq_addr, bq_data}));
  end else begin : g_rw_thru
    assign bq_en   = rw_we_raw;
    assign bq_mask = rw_wmask;
    assign bq_addr = rw_addr;
    assign bq_data = rw_wdata;
  end

  logic arr_wa_we, arr_wb_we;
  assign arr_wa_we = wq_en & wq_mask;
  assign arr_wb_we = bq_en & bq_mask;

  // ---------------- read side ----------------
  logic [AW-1:0]     arr_ra_addr, arr_rb_addr;
  logic [DATA_W-1:0] arr_ra_data, arr_rb_data;

  if (DATA_SIDE) begin : g_late_data
    // read-first: core read now, word carried through RD_LAT registers
    assign arr_ra_addr = rd_addr;
    assign arr_rb_addr = rw_addr;
    lmw_pipe #(.W(DATA_W), .N(RD_LAT), .CLR(1'b0)) u_rd_q (
      .clk(clk), .rst(rst), .d(arr_ra_data), .q(rd_data));
    lmw_pipe #(.W(DATA_W), .N(RD_LAT), .CLR(1'b0)) u_rw_q (
      .clk(clk), .rst(rst), .d(arr_rb_data), .q(rw_rdata));
  end else begin : g_early_ctl
    // write-first / undefined: enable and address registered ahead
    lmw_rd_front #(.AW(AW), .LAT(RD_LAT)) u_rd_f (
      .clk(clk), .en(rd_en), .addr(rd_addr), .addr_q(arr_ra_addr));
    lmw_rd_front #(.AW(AW), .LAT(RD_LAT)) u_rw_f (
      .clk(clk), .en(rw_re_raw), .addr(rw_addr), .addr_q(arr_rb_addr));
    assign rd_data  = arr_ra_data;
    assign rw_rdata = arr_rb_data;
  end

  lmw_array #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .wa_we   (arr_wa_we),
    .wa_addr (wq_addr),
    .wa_data (wq_data),
    .wb_we   (arr_wb_we),
    .wb_addr (bq_addr),
    .wb_data (bq_data),
    .ra_addr (arr_ra_addr),
    .ra_data (arr_ra_data),
    .rb_addr (arr_rb_addr),
    .rb_data (arr_rb_data)
  );
endmodule

// File: rtl/lmw_check.sv
module lmw_check
  import lmw_pkg::*;
#(
  parameter int   DW     = 32,
  parameter int   AW     = 5,
  parameter int   RD_LAT = 1,
  parameter int   WR_LAT = 1,
  parameter ruw_e RUW    = RUW_NEW
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic          wr_mask,
  input logic [AW-1:0] wr_addr,
  input logic          rw_en,
  input logic          rw_wmode,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] rw_rdata,
  input logic          arr_wa_we,
  input logic          arr_wb_we,
  input logic [AW-1:0] wq_addr,
  input logic [DW-1:0] arr_ra_data,
  input logic [DW-1:0] arr_rb_data
);
  localparam bit OLDP = (RUW == RUW_OLD);

  // R1: a masked-in command reaches the core one stage later (two-cycle write)
  a_r1_wr_lands: assert property (@(posedge clk) disable iff (rst)
    (WR_LAT == 2) && wr_en && wr_mask |=> arr_wa_we && (wq_addr == $past(wr_addr)));

  // R2: mask low means the core sees no store from the write port
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (WR_LAT == 1) && !wr_mask |-> !arr_wa_we);

  // R7: a shared-port read never raises the shared write enable
  a_r7_rw_split: assert property (@(posedge clk) disable iff (rst)
    (WR_LAT == 1) && rw_en && !rw_wmode |-> !arr_wb_we);

  // R10: idle read and no store leaves the write-first read data unchanged
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!OLDP && RD_LAT == 1) && !rd_en && !arr_wa_we && !arr_wb_we |=> $stable(rd_data));

  // R4: read-first data is the core word delayed by the read latency
  a_r4_old_one: assert property (@(posedge clk) disable iff (rst)
    (OLDP && RD_LAT == 1) |=> (rd_data == $past(arr_ra_data)) && (rw_rdata == $past(arr_rb_data)));
  a_r4_old_two: assert property (@(posedge clk) disable iff (rst)
    (OLDP && RD_LAT == 2) |=> (rd_data == $past(arr_ra_data, 2)) && (rw_rdata == $past(arr_rb_data, 2)));

  // R9: write enables in flight are cleared by reset
  a_r9_reset_drops: assert property (@(posedge clk) disable iff (rst)
    (WR_LAT > 1) && $past(rst) |-> !arr_wa_we && !arr_wb_we);
endmodule

bind lat_mem_wrap lmw_check #(
  .DW(DATA_W), .AW(AW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .RUW(RUW)
) u_lmw_check (.*);

// File: tb/lat_mem_wrap_test.sv
module lat_mem_wrap_test;
  import lmw_pkg::*;

  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst = 1'b1;
  logic rd_en = 0, wr_en = 0, wr_mask = 0, rw_en = 0, rw_wmode = 0, rw_wmask = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0, rw_addr = '0;
  logic [DW-1:0] wr_data = '0, rw_wdata = '0;
  logic [DW-1:0] n_rd, n_rw, o_rd, o_rw;

  lat_mem_wrap uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(n_rd),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_wmask(rw_wmask), .rw_addr(rw_addr),
    .rw_wdata(rw_wdata), .rw_rdata(n_rw));

  lat_mem_wrap #(.RD_LAT(2), .WR_LAT(2), .RUW(RUW_OLD)) uut_old (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(o_rd),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_wmask(rw_wmask), .rw_addr(rw_addr),
    .rw_wdata(rw_wdata), .rw_rdata(o_rw));

  typedef struct {
    int          due;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;

  item_t q_nr[$], q_nw[$], q_or[$], q_ow[$];
  logic [DW-1:0] ref_n [DEPTH];
  logic [DW-1:0] ref_o [DEPTH];
  logic p_we = 0, p_bwe = 0;
  logic [AW-1:0] p_addr, p_baddr;
  logic [DW-1:0] p_data, p_bdata;
  logic [AW-1:0] last_n = '0;
  int ecount = 0, nchk = 0, nfail = 0;
  bit done = 0;

  task automatic cmp(item_t it, logic [DW-1:0] act, string port);
    nchk++;
    if (act !== it.exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", it.tag, port, act, it.exp);
    end
  endtask

  // monitor: outputs settle after edge idx, sampled 1 ns later
  initial begin : monitor
    forever begin
      int idx;
      item_t it;
      @(posedge clk);
      idx = ecount;
      ecount++;
      #1;
      while (q_nr.size() > 0 && q_nr[0].due == idx) begin it = q_nr.pop_front(); cmp(it, n_rd, "wf rd_data"); end
      while (q_nw.size() > 0 && q_nw[0].due == idx) begin it = q_nw.pop_front(); cmp(it, n_rw, "wf rw_rdata"); end
      while (q_or.size() > 0 && q_or[0].due == idx) begin it = q_or.pop_front(); cmp(it, o_rd, "rf rd_data"); end
      while (q_ow.size() > 0 && q_ow[0].due == idx) begin it = q_ow.pop_front(); cmp(it, o_rw, "rf rw_rdata"); end
    end
  end

  // driver: one call per cycle; pushes expectations for both instances
  task automatic step(input bit re, input logic [AW-1:0] ra,
                      input bit we, input bit wm, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit be, input bit bmode, input bit bm, input logic [AW-1:0] ba,
                      input logic [DW-1:0] bd, input string tag, input bit hold);
    int n;
    bit wr_go, rw_go, rre, coll_r, coll_b;
    string tn, to, tb;
    @(negedge clk);
    rst = 0;
    rd_en = re; rd_addr = ra;
    wr_en = we; wr_mask = wm; wr_addr = wa; wr_data = wd;
    rw_en = be; rw_wmode = bmode; rw_wmask = bm; rw_addr = ba; rw_wdata = bd;
    n = ecount;
    wr_go = we && wm;
    rw_go = be && bmode && bm;
    rre = be && !bmode;
    coll_r = re && ((wr_go && wa == ra) || (rw_go && ba == ra));
    coll_b = rre && wr_go && wa == ba;
    tn = (tag != "") ? tag : (coll_r ? "R5" : "R3");
    to = (tag != "") ? tag : (coll_r ? "R5" : "R4");
    tb = (tag != "") ? tag : (coll_b ? "R5" : "R7");
    // read-first instance (RD_LAT=2, WR_LAT=2): sees state before edge n
    if (re)  q_or.push_back('{n + 1, ref_o[ra], to});
    if (rre) q_ow.push_back('{n + 1, ref_o[ba], tb});
    if (p_bwe) ref_o[p_baddr] = p_bdata;
    if (p_we)  ref_o[p_addr]  = p_data;
    p_we = wr_go; p_addr = wa; p_data = wd;
    p_bwe = rw_go; p_baddr = ba; p_bdata = bd;
    // write-first instance (RD_LAT=1, WR_LAT=1): sees state after edge n
    if (rw_go) ref_n[ba] = bd;
    if (wr_go) ref_n[wa] = wd;   // R8: write port applied last
    if (re) begin
      q_nr.push_back('{n, ref_n[ra], tn});
      last_n = ra;
    end else if (hold) begin
      q_nr.push_back('{n, ref_n[last_n], "R10"});
    end
    if (rre) q_nw.push_back('{n, ref_n[ba], tb});
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, '0, 0, 0, 0, '0, '0, "", 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit m, input string tag);
    step(0, '0, 1, m, a, d, 0, 0, 0, '0, '0, tag, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, a, 0, 0, '0, '0, 1, 0, 0, a, '0, tag, 0);
  endtask

  // R9: reset held with both ports trying to store
  task automatic hold_reset(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    p_we = 0;
    p_bwe = 0;
    repeat (k) begin
      @(negedge clk);
      rst = 1;
      rd_en = 0;
      wr_en = 1; wr_mask = 1; wr_addr = a; wr_data = d;
      rw_en = 1; rw_wmode = 1; rw_wmask = 1; rw_addr = a + 1'b1; rw_wdata = ~d;
    end
  endtask

  function automatic logic [AW-1:0] pick();
    if ($urandom % 2 == 0) return AW'($urandom % 4);
    return AW'($urandom);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    // R1: fill every word through the write port
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 32'hA5A5_0000 ^ (a * 32'h0101_0101), 1, "R1");
    idle(); idle();
    // R1/R7: read back through both read paths
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1");
    idle(); idle();
    // R2: masked-off store leaves word 3 intact
    wr(5'd3, 32'hFFFF_FFFF, 0, "R2");
    idle(); idle();
    rd(5'd3, "R2");
    // R6: shared-port store to word 7, read on both paths
    step(0, '0, 0, 0, '0, '0, 1, 1, 1, 5'd7, 32'h7777_0606, "R6", 0);
    step(0, '0, 0, 0, '0, '0, 1, 1, 0, 5'd8, 32'h0BAD_0BAD, "R6", 0); // rw mask off
    idle(); idle();
    rd(5'd7, "R6");
    rd(5'd8, "R6");
    // R5: read and store to word 9 in one cycle, on both read paths
    step(1, 5'd9, 1, 1, 5'd9, 32'h9999_5555, 1, 0, 0, 5'd9, '0, "R5", 0);
    idle(); idle();
    rd(5'd9, "R5");
    // R8: both ports store word 11 together
    step(0, '0, 1, 1, 5'd11, 32'h1111_8888, 1, 1, 1, 5'd11, 32'h2222_8888, "R8", 0);
    idle(); idle();
    rd(5'd11, "R8");
    // R10: read word 12, then idle reads pointing elsewhere
    step(1, 5'd12, 0, 0, '0, '0, 0, 0, 0, '0, '0, "R10", 0);
    step(0, 5'd13, 0, 0, '0, '0, 0, 0, 0, '0, '0, "", 1);
    step(0, 5'd14, 1, 1, 5'd12, 32'h1212_ABAB, 0, 0, 0, '0, '0, "", 1);
    step(0, 5'd15, 0, 0, '0, '0, 0, 0, 0, '0, '0, "", 1);
    idle(); idle();
    // R9: store in flight, then reset with stores presented
    wr(5'd20, 32'h1111_2020, 1, "R9");
    hold_reset(3, 5'd20, 32'hDEAD_BEEF);
    idle(); idle();
    rd(5'd20, "R9");
    rd(5'd21, "R9");
    // random traffic with many same-word collisions (R3, R4, R5, R7)
    for (int i = 0; i < 1500; i++) begin
      bit bmode;
      bmode = 1'($urandom);
      step(1'($urandom), pick(), 1'($urandom), ($urandom % 8) != 0, pick(), $urandom,
           1'($urandom), bmode, ($urandom % 8) != 0, pick(), $urandom, "", 0);
    end
    repeat (4) idle();
    if (q_nr.size() + q_nw.size() + q_or.size() + q_ow.size() != 0) begin
      nchk++;
      nfail++;
      $display("FAIL R3: actual %0d pending reads expected 0",
               q_nr.size() + q_nw.size() + q_or.size() + q_ow.size());
    end
    done = 1;
    finish_run();
  end
endmodule